// File: doc/BRIEF.md
# Unlock Address Chain Detector

This block watches the read traffic of a byte-wide memory and picks out two fixed chains of six read addresses. Each chain is a software command. The first five addresses are common to both chains. The sixth address chooses the command: one value asks for a nonvolatile save of the array, and the other asks for a reload of the array from nonvolatile storage. The detector only reports the request. The transfer engine that carries it out is a separate block.

The host memory controller turns each falling edge of the chip enable into a one-cycle `acc_stb` pulse in the system clock domain. In that same cycle it presents the address and the write-enable level. Each strobed access either moves the chain one step forward, restarts it, or drops it. When the sixth step matches, a single-cycle request pulse goes out. The transfer engine holds `busy` high while a nonvolatile cycle runs. During that time detection is frozen and the chain is cleared. `progress` shows how many steps are currently matched, for debug.

Top module: `nv_unlock_detect`

## Requirements
- R1: After synchronous reset, `progress` is 0 and both `store_req` and `recall_req` are low.
- R2: A save request works as follows. Send strobed reads (with `we_n`=1) of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, in that order. `store_req` is then high for exactly the one cycle after the strobe of the final read. `progress` then reads 0.
- R3: A reload request uses the same first five reads, followed by a sixth read of 0x0F0E. `recall_req` is then high for exactly the one cycle after that strobe, and `progress` returns to 0.
- R4: A strobed access with `we_n`=0 sets `progress` to 0 at any step, whatever its address. It never raises a request.
- R5: A strobed read whose address is not the next expected one sets `progress` to 0 and raises no request. The one exception is covered by R6.
- R6: A strobed read of 0x0000 that does not continue the chain makes `progress` 1. The chain restarts from its first step.
- R7: While `busy` is 1, `progress` is forced to 0 and strobes have no effect. No request is raised. After `busy` falls, the chain must start again from 0x0000.
- R8: A strobed read that matches the next expected address increases `progress` by one, for steps 0 to 4. In cycles with no strobe and no `busy`, `progress` is unchanged.
- R9: `store_req` and `recall_req` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One-cycle pulse per chip-enable-controlled access |
| we_n | input | 1 | Write-enable level at the access, low means write |
| addr | input | 13 | Access address |
| busy | input | 1 | Nonvolatile cycle in progress, freezes detection |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle reload request |
| progress | output | 3 | Number of chain steps currently matched (0..5) |

## Verification
The bound checker tests several rules on every cycle:
- the two requests never overlap, and each request lasts a single cycle;
- `progress` holds still when there is neither a strobe nor `busy`;
- a write, or `busy`, always clears the chain;
- every request is traced back to a strobed read of the correct tail address taken at step five.

Some behaviour only the bench scenarios can show. These are whether a full chain actually produces its request, whether the 0x0000 restart lands at step one, and whether an aborted chain really fails to fire later. The bench checks these with directed chains and with random traffic that is weighted toward the unlock addresses.

// File: rtl/nv_unlock_pkg.sv
package nv_unlock_pkg;

    localparam int ADDR_W  = 13;
    localparam int SEQ_LEN = 6;
    localparam int STEP_W  = $clog2(SEQ_LEN);
    localparam int STEP_N  = 2 ** STEP_W;

    localparam logic [ADDR_W-1:0] TAIL_SAVE   = 13'h0F0F;
    localparam logic [ADDR_W-1:0] TAIL_RELOAD = 13'h0F0E;
    localparam logic [ADDR_W-1:0] HEAD_ADDR   = 13'h0000;

    typedef logic [STEP_W-1:0] step_t;

    // Classification of one strobed access against the current step
    typedef struct packed {
        logic advance;   // matches next address of the common prefix
        logic restart;   // read of the head address that breaks the chain
        logic tail_save;
        logic tail_reload;
    } access_class_t;

    // Address expected at a prefix step (steps 0..SEQ_LEN-2)
    function automatic logic [ADDR_W-1:0] prefix_addr(int idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            4:       return 13'h10F0;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/nv_unlock_match.sv
module nv_unlock_match
    import nv_unlock_pkg::*;
(
    input  step_t               step,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    output access_class_t       cls
);
    localparam int LAST_STEP = SEQ_LEN - 1;

    logic [STEP_N-1:0] prefix_hit;

    // One comparator per prefix step; unused encodings never match
    for (genvar g = 0; g < STEP_N; g++) begin : g_cmp
        if (g < LAST_STEP) begin : g_live
            assign prefix_hit[g] = (addr == prefix_addr(g));
        end else begin : g_dead
            assign prefix_hit[g] = 1'b0;
        end
    end

    logic at_tail;
    assign at_tail = (step == step_t'(LAST_STEP));

    always_comb begin
        cls             = '0;
        cls.advance     = we_n && prefix_hit[step];
        cls.tail_save   = we_n && at_tail && (addr == TAIL_SAVE);
        cls.tail_reload = we_n && at_tail && (addr == TAIL_RELOAD);
        cls.restart     = we_n && (addr == HEAD_ADDR);
    end
endmodule

// File: rtl/nv_unlock_chain.sv
module nv_unlock_chain
    import nv_unlock_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_stb,
    input  logic          busy,
    input  access_class_t cls,
    output step_t         step,
    output logic          fire_save,
    output logic          fire_reload
);
    step_t step_q;
    step_t step_d;
    logic  live;

    assign live        = acc_stb && !busy;
    assign fire_save   = live && cls.tail_save;
    assign fire_reload = live && cls.tail_reload;

    always_comb begin
        step_d = step_q;
        if (busy) begin
            step_d = '0;
        end else if (acc_stb) begin
            if (cls.advance)
                step_d = step_q + step_t'(1);
            else if (cls.tail_save || cls.tail_reload)
                step_d = '0;
            else if (cls.restart)
                step_d = step_t'(1);
            else
                step_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assign step = step_q;
endmodule

// File: rtl/nv_unlock_pulse.sv
module nv_unlock_pulse (
    input  logic clk,
    input  logic rst,
    input  logic fire_save,
    input  logic fire_reload,
    output logic save_q,
    output logic reload_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            save_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            save_q   <= fire_save;
            reload_q <= fire_reload;
        end
    end
endmodule

// File: rtl/nv_unlock_detect.sv
module nv_unlock_detect
    import nv_unlock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_stb,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               busy,
    output logic               store_req,
    output logic               recall_req,
    output logic [STEP_W-1:0]  progress
);
    step_t         step;
    access_class_t cls;
    logic          fire_save;
    logic          fire_reload;

    nv_unlock_match u_match (
        .step (step),
        .we_n (we_n),
        .addr (addr),
        .cls  (cls)
    );

    nv_unlock_chain u_chain (
        .clk         (clk),
        .rst         (rst),
        .acc_stb     (acc_stb),
        .busy        (busy),
        .cls         (cls),
        .step        (step),
        .fire_save   (fire_save),
        .fire_reload (fire_reload)
    );

    nv_unlock_pulse u_pulse (
        .clk         (clk),
        .rst         (rst),
        .fire_save   (fire_save),
        .fire_reload (fire_reload),
        .save_q      (store_req),
        .reload_q    (recall_req)
    );

    assign progress = step;
endmodule

// File: rtl/nv_unlock_checker.sv
module nv_unlock_checker
    import nv_unlock_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               acc_stb,
    input logic               we_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               busy,
    input logic               store_req,
    input logic               recall_req,
    input logic [STEP_W-1:0]  progress
);
    // R1: reset leaves the chain empty and requests low
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;
    always @(negedge clk) begin
        if (rst_seen && !rst)
            a_r1_reset_idle: assert (progress == '0 && !store_req && !recall_req);
    end

    // R9: exclusive, single-cycle requests
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(store_req && recall_req));
    a_r9_save_single: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);
    a_r9_reload_single: assert property (@(posedge clk) disable iff (rst)
        recall_req |=> !recall_req);

    // R8: chain holds without a strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!acc_stb && !busy) |=> $stable(progress));

    // R7: busy clears and suppresses
    a_r7_busy_clear: assert property (@(posedge clk) disable iff (rst)
        busy |=> (progress == '0 && !store_req && !recall_req));

    // R4: a write always clears the chain
    a_r4_write_abort: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !we_n) |=> (progress == '0 && !store_req && !recall_req));

    // R2: save request traced to its tail read at step five
    a_r2_save_origin: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !busy && we_n && addr == TAIL_SAVE && progress == 3'd5)
        |=> store_req);

    // R3: reload request traced to its tail read at step five
    a_r3_reload_origin: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !busy && we_n && addr == TAIL_RELOAD && progress == 3'd5)
        |=> recall_req);

    // R5: without a full chain there is no request
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(acc_stb && !busy && we_n && progress == 3'd5 &&
          (addr == TAIL_SAVE || addr == TAIL_RELOAD)) |=> !(store_req || recall_req));
endmodule

bind nv_unlock_detect nv_unlock_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_stb    (acc_stb),
    .we_n       (we_n),
    .addr       (addr),
    .busy       (busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .progress   (progress)
);

// File: tb/nv_unlock_detect_bench.sv
module nv_unlock_detect_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_stb;
    logic        we_n;
    logic [12:0] addr;
    logic        busy;
    logic        store_req;
    logic        recall_req;
    logic [2:0]  progress;

    int n_vec  = 0;
    int n_fail = 0;
    int m_step = 0;   // bench model of matched steps

    always #2 clk = ~clk;   // 250 MHz

    nv_unlock_detect u_nv_unlock_detect (
        .clk(clk), .rst(rst), .acc_stb(acc_stb), .we_n(we_n), .addr(addr),
        .busy(busy), .store_req(store_req), .recall_req(recall_req),
        .progress(progress)
    );

    function automatic logic [12:0] chain_addr(int idx, bit reload);
        case (idx)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            4: return 13'h10F0;
            default: return reload ? 13'h0F0E : 13'h0F0F;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of one strobed access; returns expected save/reload flags
    task automatic model(input logic [12:0] a, input logic w, input logic b,
                         output bit es, output bit er);
        es = 0; er = 0;
        if (b) m_step = 0;
        else if (!w) m_step = 0;
        else if (m_step < 5 && a == chain_addr(m_step, 0)) m_step++;
        else if (m_step == 5 && a == 13'h0F0F) begin es = 1; m_step = 0; end
        else if (m_step == 5 && a == 13'h0F0E) begin er = 1; m_step = 0; end
        else if (a == 13'h0000) m_step = 1;
        else m_step = 0;
    endtask

    // Drive one strobe at a negedge, check at the next negedge, then one idle cycle
    task automatic access(input logic [12:0] a, input logic w, input logic b, string tag);
        bit es, er;
        int prev;
        acc_stb = 1; addr = a; we_n = w; busy = b;
        model(a, w, b, es, er);
        @(negedge clk);
        acc_stb = 0; busy = 0;
        check({tag, " progress"}, progress, m_step);
        check({tag, " store_req"}, store_req, es);
        check({tag, " recall_req"}, recall_req, er);
        prev = progress;
        addr = $urandom;
        @(negedge clk);
        check("R9 pulse single", store_req | recall_req, 0);
        check("R8 hold idle", progress, prev);
    endtask

    task automatic chain(bit reload, string tag);
        for (int i = 0; i < 6; i++) access(chain_addr(i, reload), 1, 0, tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0101));
        rst = 1; acc_stb = 0; we_n = 1; addr = '0; busy = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset progress", progress, 0);
        check("R1 reset store", store_req, 0);
        check("R1 reset recall", recall_req, 0);

        chain(0, "R2 save chain");
        chain(1, "R3 reload chain");
        // R4: write at step 3 aborts
        for (int i = 0; i < 3; i++) access(chain_addr(i, 0), 1, 0, "R8 step");
        access(chain_addr(3, 0), 0, 0, "R4 write abort");
        for (int i = 4; i < 6; i++) access(chain_addr(i, 0), 1, 0, "R4 after abort");
        // R5: wrong read at step 5 then tail
        for (int i = 0; i < 5; i++) access(chain_addr(i, 0), 1, 0, "R8 step");
        access(13'h0123, 1, 0, "R5 wrong addr");
        access(13'h0F0F, 1, 0, "R5 no fire");
        // R6: head read mid-chain restarts at step 1
        for (int i = 0; i < 3; i++) access(chain_addr(i, 0), 1, 0, "R8 step");
        access(13'h0000, 1, 0, "R6 restart");
        for (int i = 1; i < 6; i++) access(chain_addr(i, 1), 1, 0, "R6 resumed chain");
        // R6: repeated head read at step 1
        access(13'h0000, 1, 0, "R6 head");
        access(13'h0000, 1, 0, "R6 head again");
        // R7: busy during a chain
        for (int i = 0; i < 4; i++) access(chain_addr(i, 0), 1, 0, "R8 step");
        access(chain_addr(4, 0), 1, 1, "R7 busy strobe");
        access(chain_addr(5, 0), 1, 0, "R7 after busy");
        busy = 1; @(negedge clk);
        check("R7 busy alone", progress, 0);
        busy = 0; @(negedge clk);
        chain(0, "R7 chain after busy");

        // Random traffic biased toward the chain
        for (int k = 0; k < 3000; k++) begin
            int r;
            logic [12:0] a;
            r = $urandom_range(99);
            if (r < 70)      a = chain_addr(m_step, $urandom_range(1));
            else if (r < 80) a = 13'h0000;
            else             a = 13'($urandom);
            access(a, ($urandom_range(99) >= 5), ($urandom_range(99) < 3), "R2 R3 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_vec++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule